// File: doc/BRIEF.md
# Partitioned Shared Arithmetic Unit Scheduler

This block lets a cluster of 32 lightweight cores share a small number of copies of a large, rarely used arithmetic unit. Every core attempts to issue on every cycle, and no other thread can run while a core waits. The number of copies, `NUM_UNITS`, is a power of two from 1 to 32. Each copy serves a fixed, contiguous slice of `NUM_CORES / NUM_UNITS` cores. A core can never reach a copy outside its slice, so no full crossbar is needed.

Within a slice, a round-robin arbiter grants at most one requesting core per cycle. The granted core's two operands enter a fully pipelined unit, which accepts a new operation on every cycle. The unit is modelled as a delay line around a placeholder operation: an unsigned product with latency `LATENCY`. Each operation carries the index of the core that issued it. When the result leaves the unit, it is written back to that core alone. A core that requests and is not granted sees a stall in the same cycle and keeps requesting.

Top module: `sfu_share_sched`

## Requirements
- R1: During reset and in the first cycle after it, no result is valid. Each arbiter pointer starts at local index 0, so when every core requests in the first cycle, the lowest core of each slice is granted.
- R2: Core c is served only by unit c / (NUM_CORES/NUM_UNITS). All units grant independently in the same cycle, so with 4 units and every core requesting, exactly 4 cores are granted.
- R3: Each unit grants at most one core per cycle.
- R4: Only a requesting core is granted. The stall output of a core equals its request AND NOT its grant.
- R5: Whenever at least one core of a slice requests, that slice's unit grants one core in the same cycle.
- R6: After granting local index k, a unit next grants the first requester found at k+1, k+2, and so on, wrapping around. The pointer does not move in a cycle with no request in the slice.
- R7: If a core is granted in cycle t, its result valid is high for exactly one cycle, in cycle t+LATENCY. Its result data then equals the unsigned product of the two OP_W-bit operands presented in cycle t. No other core sees a result from that operation.
- R8: Each unit accepts a new operation every cycle. Under continuous load, every unit delivers one result per cycle once the pipeline has filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NUM_CORES | Per-core issue request |
| opa | input | NUM_CORES*OP_W | First operand of each core, core c at bits [c*OP_W +: OP_W] |
| opb | input | NUM_CORES*OP_W | Second operand of each core, same packing |
| grant | output | NUM_CORES | Core accepted this cycle (combinational on req) |
| stall | output | NUM_CORES | Core requested but was not accepted this cycle |
| res_valid | output | NUM_CORES | Result for this core is present this cycle |
| res_data | output | NUM_CORES*2*OP_W | Result of each core, core c at bits [c*2*OP_W +: 2*OP_W] |

## Verification
A corrupted arbiter pointer shows up in the very next contended cycle: the grant pattern inside a slice moves away from strict rotation. A pointer that drifts while the slice is idle is exposed by the first request after the idle gap. An error in the pipeline's valid or tag stage takes exactly LATENCY cycles to appear. It appears as a result pulse on the wrong core, a missing pulse, or a product that does not match the operands captured at the grant. The bench keeps its own pointer per slice and a schedule of expected results. It compares every grant, stall and result output on every cycle, so any divergence is reported in the cycle where it first becomes visible.

// File: rtl/sfu_pkg.sv
// Package of shared helpers for the shared-unit scheduler.
// Assumes widths are positive; callers pass counts of at least 1.
package sfu_pkg;

    // Index width that stays at least one bit wide for a count of 1
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sfu_rr_arb.sv
// Round-robin arbiter for one slice of cores sharing one unit.
// Grant is combinational on req. The pointer moves to the index after
// the granted one and holds in cycles with no request.
// Assumes GROUP is a power of two, at least 1.
module sfu_rr_arb #(
    parameter int GROUP = 8,
    localparam int IW = sfu_pkg::idx_width(GROUP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GROUP-1:0] req,
    output logic [GROUP-1:0] grant,
    output logic             any_grant,
    output logic [IW-1:0]    grant_idx
);

    logic [IW-1:0] ptr_q;

    // Search the request vector starting at the pointer, wrapping around
    always_comb begin
        logic [IW-1:0] cand;
        grant     = '0;
        any_grant = 1'b0;
        grant_idx = '0;
        for (int k = 0; k < GROUP; k++) begin
            cand = IW'((int'(ptr_q) + k) % GROUP);
            if (!any_grant && req[cand]) begin
                any_grant   = 1'b1;
                grant[cand] = 1'b1;
                grant_idx   = cand;
            end
        end
    end

    // Advance the pointer past the winner; hold it when the slice is idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (any_grant)
            ptr_q <= (grant_idx == IW'(GROUP - 1)) ? '0 : grant_idx + 1'b1;
    end

    // R3
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R4
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    // R5
    no_idle_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|grant));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req) |=> $stable(ptr_q));

endmodule

// File: rtl/sfu_pipe.sv
// Fully pipelined placeholder arithmetic unit: registers the unsigned
// product of two operands at issue, then delays it with its owner tag
// through LATENCY-1 further stages. Accepts one operation per cycle.
// Assumes LATENCY >= 1. Only the valid bits are reset.
module sfu_pipe #(
    parameter int LATENCY = 3,
    parameter int TAG_W   = 3,
    parameter int OP_W    = 16,
    localparam int RES_W  = 2 * OP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [OP_W-1:0]  in_a,
    input  logic [OP_W-1:0]  in_b,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic [RES_W-1:0] out_res
);

    logic [LATENCY-1:0] v_q;
    logic [TAG_W-1:0]   tag_q [LATENCY];
    logic [RES_W-1:0]   res_q [LATENCY];

    // Valid shift chain, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            v_q <= '0;
        else
            v_q <= {v_q[LATENCY-2 >= 0 ? LATENCY-2 : 0 : 0] & {(LATENCY > 1 ? LATENCY-1 : 1){LATENCY > 1}}, in_valid} & {LATENCY{1'b1}};
    end

    // Data and tag chain; first stage computes the placeholder product
    always_ff @(posedge clk) begin
        tag_q[0] <= in_tag;
        res_q[0] <= RES_W'(in_a) * RES_W'(in_b);
        for (int s = 1; s < LATENCY; s++) begin
            tag_q[s] <= tag_q[s-1];
            res_q[s] <= res_q[s-1];
        end
    end

    assign out_valid = v_q[LATENCY-1];
    assign out_tag   = tag_q[LATENCY-1];
    assign out_res   = res_q[LATENCY-1];

endmodule

// File: rtl/sfu_share_sched.sv
// Shares NUM_UNITS pipelined arithmetic units among NUM_CORES cores.
// Core c belongs to slice c / GROUP. Each slice has its own round-robin
// arbiter and pipeline, and results return to the core named by the tag.
// Assumes NUM_UNITS is a power of two dividing NUM_CORES.
module sfu_share_sched #(
    parameter int NUM_CORES = 32,
    parameter int NUM_UNITS = 4,
    parameter int OP_W      = 16,
    parameter int LATENCY   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CORES-1:0]       req,
    input  logic [NUM_CORES*OP_W-1:0]  opa,
    input  logic [NUM_CORES*OP_W-1:0]  opb,
    output logic [NUM_CORES-1:0]       grant,
    output logic [NUM_CORES-1:0]       stall,
    output logic [NUM_CORES-1:0]       res_valid,
    output logic [NUM_CORES*2*OP_W-1:0] res_data
);

    localparam int GROUP = NUM_CORES / NUM_UNITS;
    localparam int TAG_W = sfu_pkg::idx_width(GROUP);
    localparam int RES_W = 2 * OP_W;

    logic [NUM_UNITS-1:0] unit_any;
    logic [NUM_UNITS-1:0] unit_v;
    logic [TAG_W-1:0]     unit_gidx [NUM_UNITS];
    logic [TAG_W-1:0]     unit_tag  [NUM_UNITS];
    logic [RES_W-1:0]     unit_res  [NUM_UNITS];
    logic [OP_W-1:0]      unit_a    [NUM_UNITS];
    logic [OP_W-1:0]      unit_b    [NUM_UNITS];

    // Losers of arbitration stall in the same cycle
    assign stall = req & ~grant;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        sfu_rr_arb #(.GROUP(GROUP)) arb_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req[u*GROUP +: GROUP]),
            .grant     (grant[u*GROUP +: GROUP]),
            .any_grant (unit_any[u]),
            .grant_idx (unit_gidx[u])
        );

        // Operand select from the winning core of this slice
        assign unit_a[u] = opa[(u*GROUP + int'(unit_gidx[u]))*OP_W +: OP_W];
        assign unit_b[u] = opb[(u*GROUP + int'(unit_gidx[u]))*OP_W +: OP_W];

        sfu_pipe #(.LATENCY(LATENCY), .TAG_W(TAG_W), .OP_W(OP_W)) pipe_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (unit_any[u]),
            .in_tag    (unit_gidx[u]),
            .in_a      (unit_a[u]),
            .in_b      (unit_b[u]),
            .out_valid (unit_v[u]),
            .out_tag   (unit_tag[u]),
            .out_res   (unit_res[u])
        );

        // Write-back decode: the result pulses only on the tagged core
        for (genvar j = 0; j < GROUP; j++) begin : g_core
            assign res_valid[u*GROUP + j] = unit_v[u] && (unit_tag[u] == TAG_W'(j));
            assign res_data[(u*GROUP + j)*RES_W +: RES_W] = unit_res[u];
        end

        // R7
        one_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(res_valid[u*GROUP +: GROUP]));
    end

endmodule

// File: tb/sfu_share_sched_tb.sv
// Directed bench with a per-cycle reference model of the slices.
module sfu_share_sched_tb_top;

    localparam int C = 32;
    localparam int N = 4;
    localparam int G = C / N;
    localparam int W = 16;
    localparam int L = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [C-1:0]    req = '0;
    logic [C*W-1:0]  opa = '0;
    logic [C*W-1:0]  opb = '0;
    logic [C-1:0]    grant, stall, res_valid;
    logic [C*2*W-1:0] res_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int mptr [N];
    logic [C-1:0]   exp_v [8];
    logic [2*W-1:0] exp_d [8][C];
    logic [C-1:0]   obs_grant;
    logic [C-1:0]   obs_rv;
    bit big_ops = 1'b0;

    always #10 clk = ~clk;

    sfu_share_sched #(.NUM_CORES(C), .NUM_UNITS(N), .OP_W(W), .LATENCY(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .opa(opa), .opb(opb),
        .grant(grant), .stall(stall), .res_valid(res_valid), .res_data(res_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic model_clear();
        for (int u = 0; u < N; u++) mptr[u] = 0;
        for (int s = 0; s < 8; s++) begin
            exp_v[s] = '0;
            for (int c = 0; c < C; c++) exp_d[s][c] = '0;
        end
        cyc = 0;
    endtask

    // One cycle: drive, compare against the model, advance the model
    task automatic step(input logic [C-1:0] rq);
        logic [C-1:0] gexp;
        int slot;
        @(negedge clk);
        req = rq;
        for (int c = 0; c < C; c++) begin
            opa[c*W +: W] = big_ops ? 16'hFFFF : W'(c*37 + cyc*11 + 5);
            opb[c*W +: W] = big_ops ? ((c % 2) ? 16'hFFFF : 16'h0000) : W'((c*91) ^ (cyc*5) ^ 3);
        end
        #2;
        obs_grant = grant;
        obs_rv = res_valid;
        gexp = '0;
        for (int u = 0; u < N; u++) begin
            int g = -1;
            for (int k = 0; k < G; k++) begin
                int idx = (mptr[u] + k) % G;
                if (g < 0 && rq[u*G + idx]) g = idx;
            end
            if (g >= 0) begin
                gexp[u*G + g] = 1'b1;
                mptr[u] = (g + 1) % G;
            end
        end
        check("R2 R5 R6 grant", 64'(grant), 64'(gexp));
        check("R4 stall", 64'(stall), 64'(rq & ~gexp));
        slot = cyc % 8;
        check("R7 result valid", 64'(res_valid), 64'(exp_v[slot]));
        for (int c = 0; c < C; c++)
            if (exp_v[slot][c])
                check("R7 result data", 64'(res_data[c*2*W +: 2*W]), 64'(exp_d[slot][c]));
        exp_v[slot] = '0;
        slot = (cyc + L) % 8;
        for (int c = 0; c < C; c++)
            if (gexp[c]) begin
                exp_v[slot][c] = 1'b1;
                exp_d[slot][c] = 32'(opa[c*W +: W]) * 32'(opb[c*W +: W]);
            end
        cyc++;
    endtask

    // R1: reset state and first grants
    task automatic t_reset();
        rst_n = 1'b0;
        req = '0;
        model_clear();
        repeat (3) @(negedge clk);
        #2;
        check("R1 no result in reset", 64'(res_valid), 64'd0);
        rst_n = 1'b1;
        step('1);
        check("R1 lowest core first", 64'(obs_grant), 64'h0000_0000_0101_0101);
    endtask

    // R2: one requester per slice at different local positions
    task automatic t_single();
        for (int i = 0; i < 6; i++) begin
            logic [C-1:0] rq = '0;
            for (int u = 0; u < N; u++) rq[u*G + ((i + u*3) % G)] = 1'b1;
            step(rq);
            check("R2 slices in parallel", 64'($countones(obs_grant)), 64'(N));
        end
    endtask

    // R3, R8: every core requests continuously
    task automatic t_full_load();
        for (int i = 0; i < 20; i++) begin
            step('1);
            for (int u = 0; u < N; u++)
                check("R3 one grant per unit", 64'($countones(obs_grant[u*G +: G])), 64'd1);
            if (i >= L)
                check("R8 one result per unit per cycle", 64'($countones(obs_rv)), 64'(N));
        end
    endtask

    // R6: pointer holds across idle cycles, then wraps correctly
    task automatic t_hold_wrap();
        step(C'(1) << 1);
        repeat (3) step('0);
        step((C'(1) << 0) | (C'(1) << 5));
        check("R6 pointer held while idle", 64'(obs_grant[G-1:0]), 64'h20);
        step((C'(1) << 0) | (C'(1) << 5));
        check("R6 wrap to lower index", 64'(obs_grant[G-1:0]), 64'h01);
        step((C'(1) << 7) | (C'(1) << 2));
        check("R6 next after 0", 64'(obs_grant[G-1:0]), 64'h04);
        repeat (L + 1) step('0);
    endtask

    // R7: extreme operands
    task automatic t_extremes();
        big_ops = 1'b1;
        for (int i = 0; i < 10; i++) step('1);
        big_ops = 1'b0;
        repeat (L + 1) step('0);
        check("R7 drained", 64'(obs_rv), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_full_load();
        t_hold_wrap();
        t_extremes();
        t_reset();
        t_full_load();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule